// File: doc/BRIEF.md
# Dual Microsecond Countdown Timer Pair

This block provides two independent 16-bit countdown timers behind a small byte-wide register window. A prescaler divides the system clock by `CLK_MHZ` to produce a single-cycle enable once per microsecond, and every running timer steps down by one on that enable. Software loads a timer by writing its low byte, which is only held in a reload latch, and then its high byte, which completes the latch and copies the whole 16-bit latch value into the counter. Reading the two counter bytes returns the microseconds still remaining.

When a running counter is at zero and a tick arrives, it wraps by reloading from its latch and raises the timer's pending flag. A shared interrupt register holds an enable mask, which is written with set/clear semantics, and the pending flags, which are cleared by reading them. The level interrupt output is high while any enabled flag is pending. Each timer has a control byte with a start bit and a one-shot bit. In one-shot mode the timer halts by itself after its first wrap.

Each timer is driven by a two-state machine. `T_HALT` is the stopped state: the counter holds. `T_RUN` is the counting state: the counter decrements on every tick. The transition *start* (`T_HALT`→`T_RUN`) is taken on a control write with bit 0 = 1. The transition *stop* (`T_RUN`→`T_HALT`) is taken on a control write with bit 0 = 0. The transition *expire* (`T_RUN`→`T_HALT`) is taken on a wrap while the one-shot bit is set. A control write to a running timer with bit 0 = 1 keeps it in `T_RUN`.

Top module: `usec_timer_pair`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF, both control bytes read 0x00, the interrupt register reads 0x00 and `irq` is low.
- R2: A write to a timer's low-byte offset (timer 0 at 0, timer 1 at 2) updates only the latch low byte, and the counter is left unchanged.
- R3: A write to a timer's high-byte offset (timer 0 at 1, timer 1 at 3) sets the latch high byte and loads the counter with {written byte, latched low byte} at the next edge.
- R4: Reads at offsets 0/1 (timer 0) and 2/3 (timer 1) return the counter low and high bytes. Offset 4 reads 0x00.
- R5: A timer in `T_RUN` decrements once per microsecond tick (one tick every `CLK_MHZ` clocks). A timer in `T_HALT` holds its count.
- R6: A tick arriving while a running counter is 0 reloads the counter from the latch and sets that timer's pending flag. In continuous mode (control bit 3 = 0) the timer stays in `T_RUN`.
- R7: With control bit 3 = 1, the wrap also moves the timer to `T_HALT`, so its control byte then reads bit 0 = 0.
- R8: A write to offset 5 with bit 7 = 1 sets the mask bits that are 1 in bits 1:0. With bit 7 = 0 it clears them. Bit 0 is the timer 0 enable and bit 1 is the timer 1 enable.
- R9: A read of offset 5 returns the pending flags in bits 1:0, and bit 7 = 1 if any enabled flag is pending. The read clears all pending flags, though a wrap in the same cycle is kept.
- R10: `irq` is high exactly while some pending flag has its mask bit set.
- R11: Timer 1 behaves like timer 0 at offsets 2, 3 and 7, uses pending/mask bit 1, and does not disturb timer 0.
- R12: Control bytes (offset 6 for timer 0, 7 for timer 1) store only bit 0 (start/run state) and bit 3 (one-shot). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read when `sel` is high |
| addr | input | 3 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that every access is a single-cycle `sel` pulse with `wr` and `addr` stable during that cycle. They also assume that a read of offset 5 is a deliberate acknowledge, because its side effect fires on any `sel` cycle with `wr` low. The stimulus issues only isolated one-cycle accesses with idle cycles between them. Counting is checked against a tolerance window, because the prescaler phase is free-running relative to the start write. Wrap tests use waits of several full tick periods, so that each timer expires well before it is sampled.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
    typedef enum logic {
        T_HALT = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_e;

    localparam int NUM_TMR   = 2;
    localparam int CNT_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam logic [ADDR_W-1:0] OFS_INT  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_CTL0 = 3'd6;
    localparam int CTL_RUN_BIT = 0;
    localparam int CTL_OS_BIT  = 3;
    localparam int INT_SET_BIT = 7;
endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int CLK_MHZ = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

    generate
        if (CLK_MHZ <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_divide
            localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);
            logic [PW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/down_timer.sv
module down_timer
    import usec_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ctl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  latch,
    output logic              run,
    output logic              oneshot,
    output logic              uflow
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, lat_q;
    logic             os_q;

    assign uflow = (state_q == T_RUN) && tick && (cnt_q == '0) && !wr_hi;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= T_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_HALT: begin
                if (wr_ctl && wdata[CTL_RUN_BIT]) state_d = T_RUN;     // start
            end
            T_RUN: begin
                if (wr_ctl)              state_d = wdata[CTL_RUN_BIT] ? T_RUN : T_HALT; // stop
                else if (uflow && os_q)  state_d = T_HALT;                              // expire
            end
            default: state_d = T_HALT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            lat_q <= '1;
            os_q  <= 1'b0;
        end else begin
            if (wr_ctl) os_q <= wdata[CTL_OS_BIT];
            if (wr_lo)  lat_q[BYTE_W-1:0] <= wdata;
            if (wr_hi) begin
                lat_q[CNT_W-1:BYTE_W] <= wdata;
                cnt_q <= {wdata, lat_q[BYTE_W-1:0]};
            end else if (state_q == T_RUN && tick) begin
                cnt_q <= (cnt_q == '0) ? lat_q : cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        run     = (state_q == T_RUN);
        oneshot = os_q;
        count   = cnt_q;
        latch   = lat_q;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import usec_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] uflow,
    input  logic               wr_int,
    input  logic               rd_int,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [NUM_TMR-1:0] pend,
    output logic [NUM_TMR-1:0] mask,
    output logic [BYTE_W-1:0]  int_rdata,
    output logic               irq
);
    logic [NUM_TMR-1:0] pend_q, mask_q;
    logic               any_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (rd_int ? '0 : pend_q) | uflow;
            if (wr_int) begin
                if (wdata[INT_SET_BIT]) mask_q <= mask_q | wdata[NUM_TMR-1:0];
                else                    mask_q <= mask_q & ~wdata[NUM_TMR-1:0];
            end
        end
    end

    always_comb begin
        any_en    = |(pend_q & mask_q);
        int_rdata = '0;
        int_rdata[NUM_TMR-1:0] = pend_q;
        int_rdata[INT_SET_BIT] = any_en;
        irq  = any_en;
        pend = pend_q;
        mask = mask_q;
    end
endmodule

// File: rtl/usec_timer_pair.sv
module usec_timer_pair
    import usec_timer_pkg::*;
#(
    parameter int CLK_MHZ = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        wr,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq
);
    logic               tick_us;
    logic [NUM_TMR-1:0] run_v, os_v, uf_v, pend_v, mask_v;
    logic [CNT_W-1:0]   cnt_arr [NUM_TMR];
    logic [CNT_W-1:0]   lat_arr [NUM_TMR];
    logic [BYTE_W-1:0]  int_rd;
    logic               wr_int, rd_int;

    us_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick_us)
    );

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(2 * i);
            localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(2 * i + 1);
            localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(int'(OFS_CTL0) + i);
            down_timer u_t (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick_us),
                .wr_lo  (sel && wr && addr == A_LO),
                .wr_hi  (sel && wr && addr == A_HI),
                .wr_ctl (sel && wr && addr == A_CTL),
                .wdata  (wdata),
                .count  (cnt_arr[i]),
                .latch  (lat_arr[i]),
                .run    (run_v[i]),
                .oneshot(os_v[i]),
                .uflow  (uf_v[i])
            );
        end
    endgenerate

    assign wr_int = sel && wr && addr == OFS_INT;
    assign rd_int = sel && !wr && addr == OFS_INT;

    irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .uflow    (uf_v),
        .wr_int   (wr_int),
        .rd_int   (rd_int),
        .wdata    (wdata),
        .pend     (pend_v),
        .mask     (mask_v),
        .int_rdata(int_rd),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            3'd0: rdata = cnt_arr[0][BYTE_W-1:0];
            3'd1: rdata = cnt_arr[0][CNT_W-1:BYTE_W];
            3'd2: rdata = cnt_arr[1][BYTE_W-1:0];
            3'd3: rdata = cnt_arr[1][CNT_W-1:BYTE_W];
            3'd4: rdata = '0;
            3'd5: rdata = int_rd;
            3'd6: begin
                rdata[CTL_RUN_BIT] = run_v[0];
                rdata[CTL_OS_BIT]  = os_v[0];
            end
            3'd7: begin
                rdata[CTL_RUN_BIT] = run_v[1];
                rdata[CTL_OS_BIT]  = os_v[1];
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/timer_chk.sv
module timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr,
    input logic [2:0]  addr,
    input logic [7:0]  wdata,
    input logic        irq,
    input logic        tick,
    input logic [1:0]  run,
    input logic [1:0]  pend,
    input logic [1:0]  mask,
    input logic [15:0] cnt0,
    input logic [15:0] lat0
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == 2'b00 && !irq)); // R1

    AST_HI_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == 3'd1) |=> (cnt0 == {$past(wdata), $past(lat0[7:0])})); // R3

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !(sel && wr && addr == 3'd1)) |=> $stable(cnt0)); // R5

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && tick && cnt0 != 16'd0 && !(sel && wr && addr == 3'd1))
        |=> (cnt0 == $past(cnt0) - 16'd1)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == 3'd5 && !tick) |=> (pend == 2'b00)); // R9

    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq); // R10
endmodule

bind usec_timer_pair timer_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel),
    .wr   (wr),
    .addr (addr),
    .wdata(wdata),
    .irq  (irq),
    .tick (tick_us),
    .run  (run_v),
    .pend (pend_v),
    .mask (mask_v),
    .cnt0 (cnt_arr[0]),
    .lat0 (lat_arr[0])
);

// File: tb/tb_usec_timer_pair.sv
module tb_usec_timer_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    usec_timer_pair #(.CLK_MHZ(4)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: compares every scoreboard read as it is presented
    always @(negedge clk) begin
        if (sel && !wr && sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: addr %0d got %02h expected %02h", it.tag, addr, rdata, it.exp);
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        sel = 1'b1; wr = 1'b0; addr = a;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        v = rdata;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_vec++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %0b expected %0b", tag, irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lo, hi;
        int cnt;
        idle(3); #1;
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1 irq");
        reg_rd(3'd0, 8'hFF, "R1 cnt0 lo");
        reg_rd(3'd1, 8'hFF, "R1 cnt0 hi");
        reg_rd(3'd3, 8'hFF, "R1 cnt1 hi");
        reg_rd(3'd5, 8'h00, "R1 int");
        reg_rd(3'd6, 8'h00, "R1 ctl0");
        reg_rd(3'd7, 8'h00, "R1 ctl1");

        // R2 low write latches only
        reg_wr(3'd0, 8'h34);
        reg_rd(3'd0, 8'hFF, "R2 lo unchanged");
        // R3 high write loads counter, R4 read back
        reg_wr(3'd1, 8'h12);
        reg_rd(3'd0, 8'h34, "R3 R4 cnt0 lo");
        reg_rd(3'd1, 8'h12, "R3 R4 cnt0 hi");
        reg_rd(3'd4, 8'h00, "R4 offset4");

        // R11 timer 1 independent of timer 0
        reg_wr(3'd2, 8'hCD);
        reg_wr(3'd3, 8'hAB);
        reg_rd(3'd2, 8'hCD, "R11 cnt1 lo");
        reg_rd(3'd3, 8'hAB, "R11 cnt1 hi");
        reg_rd(3'd0, 8'h34, "R11 cnt0 kept");

        // R12 control byte keeps bits 0 and 3 only
        reg_wr(3'd6, 8'hF6);
        reg_rd(3'd6, 8'h00, "R12 ctl0 F6");
        reg_wr(3'd6, 8'hF8);
        reg_rd(3'd6, 8'h08, "R12 ctl0 F8");
        reg_wr(3'd6, 8'h00);

        // R5 halted timer holds
        idle(40);
        reg_rd(3'd1, 8'h12, "R5 halted hold");

        // R5 counting rate: load 1000, run about 81 clocks
        reg_wr(3'd0, 8'hE8);
        reg_wr(3'd1, 8'h03);
        reg_wr(3'd6, 8'h01);
        idle(80);
        reg_wr(3'd6, 8'h00);
        peek(3'd0, lo);
        peek(3'd1, hi);
        cnt = int'({hi, lo});
        n_vec++;
        if (cnt < 978 || cnt > 981) begin
            n_bad++;
            $display("FAIL R5 rate: count %0d expected 978..981", cnt);
        end

        // R7 one-shot expires and reloads, R9 pending without mask
        reg_wr(3'd0, 8'h03);
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd6, 8'h09);
        idle(60);
        reg_rd(3'd6, 8'h08, "R7 ctl0 halted");
        reg_rd(3'd0, 8'h03, "R6 R7 reloaded");
        chk_irq(1'b0, "R10 masked");
        reg_rd(3'd5, 8'h01, "R9 pend0 unmasked");
        reg_rd(3'd5, 8'h00, "R9 cleared");

        // R8 set mask, R6 continuous wrap, R10 irq
        reg_wr(3'd5, 8'h81);
        chk_irq(1'b0, "R10 nothing pending");
        reg_wr(3'd0, 8'h02);
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd6, 8'h01);
        idle(40);
        chk_irq(1'b1, "R10 irq raised");
        reg_rd(3'd6, 8'h01, "R6 still running");
        reg_wr(3'd6, 8'h00);
        reg_rd(3'd5, 8'h81, "R9 enabled pend");
        chk_irq(1'b0, "R9 R10 ack drops irq");
        reg_rd(3'd5, 8'h00, "R9 cleared again");

        // R8 clear mask; R11 timer 1 one-shot uses bit 1
        reg_wr(3'd5, 8'h01);
        reg_wr(3'd2, 8'h01);
        reg_wr(3'd3, 8'h00);
        reg_wr(3'd7, 8'h09);
        idle(40);
        chk_irq(1'b0, "R8 mask cleared");
        reg_rd(3'd7, 8'h08, "R11 ctl1 expired");
        reg_rd(3'd5, 8'h02, "R11 pend1");
        reg_wr(3'd5, 8'h82);
        reg_wr(3'd7, 8'h09);
        idle(40);
        chk_irq(1'b1, "R11 irq from timer 1");
        reg_rd(3'd5, 8'h82, "R11 int with bit7");
        chk_irq(1'b0, "R11 ack");

        idle(4);
        n_vec++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R4 scoreboard: %0d left expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule